// File: doc/BRIEF.md
# Auto-Reload Decrementer Timer

The block holds a down-counter that software may load at any time, a reload value register, and a two-bit control word. The control word has an auto-reload enable and an interrupt enable. Each cycle in which `tick_en` is high moves an armed counter one step toward zero. When the counter gets there, the block records an expiry event in a sticky status bit. It then either restarts from the reload value or stops at zero until software loads it again. The interrupt output is the status bit gated by the interrupt enable. Software clears the status bit by writing a one to it.

A small state machine controls the counter. It has three states:
- `ST_STOP`: the counter is zero and idle, and ticks have no effect.
- `ST_COUNT`: the counter is non-zero and decrements on each tick.
- `ST_ZPEND`: software loaded zero, and the next tick is an expiry.

The transitions are:
- **load**: from any state, to `ST_COUNT` for a non-zero value or to `ST_ZPEND` for zero.
- **expire-reload**: from `ST_COUNT` at a count of one, or from `ST_ZPEND` on a tick, when auto-reload is on and the reload value is non-zero. The next state is `ST_COUNT`.
- **expire-stop**: the same events, when auto-reload is off or the reload value is zero. The next state is `ST_STOP`.

Top module: `dec_timer_top`

## Requirements
- R1: After reset the counter, reload value, control word and status bit are all zero and `dec_irq` is low. Ticks after reset cause no expiry until software loads the counter.
- R2: A counter write (`cnt_wr`) loads `cnt_wdata` at the next edge. It takes priority over a tick or an expiry in the same cycle, and that cycle produces no expiry.
- R3: In `ST_COUNT`, each cycle with `tick_en` high and a count above one decrements the counter by one. Without a tick the counter holds its value.
- R4: An expiry occurs on a tick when the count is one, or on the first tick after zero was loaded.
- R5: An expiry sets the status bit at the same edge. `dec_irq` is high exactly while the status bit and the interrupt enable (control bit 1) are both 1.
- R6: At an expiry with auto-reload enabled (control bit 0) and a non-zero reload value, the counter takes the reload value and continues counting.
- R7: At an expiry with auto-reload disabled or a reload value of zero, the counter stays at zero. No further expiry occurs until the next counter write.
- R8: The status bit is sticky. A status write (`sts_clr_wr`) with `sts_clr_wdata` = 1 clears it, and one with data 0 has no effect. An expiry in the same cycle as a clear leaves the bit set.
- R9: Clearing the interrupt enable drops `dec_irq` at the next edge while the status bit stays set. The control word reads back as written: bit 0 is auto-reload, bit 1 is interrupt enable.
- R10: Reload and control writes take effect at the next edge. An expiry in the same cycle uses the values held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable for one step |
| cnt_wr | input | 1 | Counter write strobe |
| cnt_wdata | input | CNT_W | Counter write value |
| rld_wr | input | 1 | Reload register write strobe |
| rld_wdata | input | CNT_W | Reload register write value |
| ctl_wr | input | 1 | Control write strobe |
| ctl_wdata | input | 2 | Bit 0 auto-reload enable, bit 1 interrupt enable |
| sts_clr_wr | input | 1 | Status write strobe |
| sts_clr_wdata | input | 1 | 1 clears the status bit |
| cnt_rdata | output | CNT_W | Current counter value |
| rld_rdata | output | CNT_W | Reload register value |
| ctl_rdata | output | 2 | Control word |
| sts_rdata | output | 1 | Sticky expiry status |
| dec_irq | output | 1 | Interrupt request |

## Verification
Two coincidences are provoked on purpose:
- **Expiry with a status clear.** The bench raises the clear strobe in the very cycle a reload expiry happens and expects the status to read back set.
- **Expiry with a reload write.** The bench writes a new reload value in the cycle of an expiry and expects the old value in the counter, then the new one at the following expiry.

A counter write together with a tick at count one is also judged: the loaded value must win and no status must appear. A behavioural model in the bench is compared against every output on each clock, so any cycle where these functions collide is judged as well.

// File: rtl/dec_pkg.sv
package dec_pkg;
    localparam int CTL_W = 2;

    typedef enum logic [1:0] {
        ST_STOP  = 2'd0,
        ST_COUNT = 2'd1,
        ST_ZPEND = 2'd2
    } dec_state_e;

    typedef struct packed {
        logic ie;   // bit 1
        logic are;  // bit 0
    } dec_ctl_t;
endpackage

// File: rtl/dec_cfg_regs.sv
module dec_cfg_regs
    import dec_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rld_wr,
    input  logic [CNT_W-1:0] rld_din,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_din,
    output logic [CNT_W-1:0] rld_q,
    output dec_ctl_t         ctl_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rld_q <= '0;
            ctl_q <= '0;
        end else begin
            if (rld_wr) rld_q <= rld_din;
            if (ctl_wr) ctl_q <= dec_ctl_t'(ctl_din);
        end
    end
endmodule

// File: rtl/dec_core.sv
module dec_core
    import dec_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_wr,
    input  logic [CNT_W-1:0] load_din,
    input  logic             are,
    input  logic [CNT_W-1:0] rld,
    output logic [CNT_W-1:0] cnt_q,
    output dec_state_e       state_q,
    output logic             expire
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    dec_state_e       state_d;
    logic [CNT_W-1:0] cnt_d;
    logic             reload_ok;
    logic             at_last;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        reload_ok = are && (rld != '0);
        at_last   = (cnt_q == ONE);
        state_d   = state_q;
        unique case (state_q)
            ST_STOP:  state_d = ST_STOP;
            ST_COUNT: if (tick && at_last) state_d = reload_ok ? ST_COUNT : ST_STOP;
            ST_ZPEND: if (tick)            state_d = reload_ok ? ST_COUNT : ST_STOP;
            default:  state_d = ST_STOP;
        endcase
        if (load_wr) state_d = (load_din != '0) ? ST_COUNT : ST_ZPEND;
    end

    // outputs: expiry pulse and counter value
    always_comb begin
        expire = 1'b0;
        unique case (state_q)
            ST_COUNT: expire = tick && at_last;
            ST_ZPEND: expire = tick;
            default:  expire = 1'b0;
        endcase
        if (load_wr) expire = 1'b0;

        cnt_d = cnt_q;
        if (load_wr)
            cnt_d = load_din;
        else if (expire)
            cnt_d = reload_ok ? rld : '0;
        else if (tick && state_q == ST_COUNT)
            cnt_d = cnt_q - ONE;
    end
endmodule

// File: rtl/dec_status.sv
module dec_status (
    input  logic clk,
    input  logic rst_n,
    input  logic expire,
    input  logic clr_wr,
    input  logic clr_din,
    input  logic ie,
    output logic sts_q,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (!rst_n)               sts_q <= 1'b0;
        else if (expire)          sts_q <= 1'b1;
        else if (clr_wr && clr_din) sts_q <= 1'b0;
    end

    assign irq = sts_q & ie;
endmodule

// File: rtl/dec_timer_top.sv
module dec_timer_top
    import dec_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_en,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             rld_wr,
    input  logic [CNT_W-1:0] rld_wdata,
    input  logic             ctl_wr,
    input  logic [1:0]       ctl_wdata,
    input  logic             sts_clr_wr,
    input  logic             sts_clr_wdata,
    output logic [CNT_W-1:0] cnt_rdata,
    output logic [CNT_W-1:0] rld_rdata,
    output logic [1:0]       ctl_rdata,
    output logic             sts_rdata,
    output logic             dec_irq
);
    dec_ctl_t         ctl_q;
    logic [CNT_W-1:0] rld_q;
    logic [CNT_W-1:0] cnt_q;
    dec_state_e       state_q;
    logic             expire;
    logic             sts_q;
    logic             irq;

    dec_cfg_regs #(.CNT_W(CNT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .rld_wr(rld_wr), .rld_din(rld_wdata),
        .ctl_wr(ctl_wr), .ctl_din(ctl_wdata),
        .rld_q(rld_q), .ctl_q(ctl_q)
    );

    dec_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick_en),
        .load_wr(cnt_wr), .load_din(cnt_wdata),
        .are(ctl_q.are), .rld(rld_q),
        .cnt_q(cnt_q), .state_q(state_q), .expire(expire)
    );

    dec_status u_sts (
        .clk(clk), .rst_n(rst_n), .expire(expire),
        .clr_wr(sts_clr_wr), .clr_din(sts_clr_wdata),
        .ie(ctl_q.ie), .sts_q(sts_q), .irq(irq)
    );

    assign cnt_rdata = cnt_q;
    assign rld_rdata = rld_q;
    assign ctl_rdata = ctl_q;
    assign sts_rdata = sts_q;
    assign dec_irq   = irq;
endmodule

// File: rtl/dec_timer_chk.sv
module dec_timer_chk
    import dec_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt_wdata,
    input logic             sts_clr_wr,
    input logic             sts_clr_wdata,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] rld_q,
    input dec_ctl_t         ctl_q,
    input dec_state_e       state_q,
    input logic             expire,
    input logic             sts_q,
    input logic             irq
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_COUNT |-> cnt_q != '0);  // R3
    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_wr && tick_en && state_q == ST_COUNT && cnt_q != ONE) |=> cnt_q == $past(cnt_q) - ONE);  // R3
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> cnt_q == $past(cnt_wdata));  // R2
    AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> sts_q);  // R5
    AST_RELOAD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ctl_q.are && rld_q != '0) |=> cnt_q == $past(rld_q));  // R6
    AST_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !(ctl_q.are && rld_q != '0)) |=> (cnt_q == '0 && state_q == ST_STOP));  // R7
    AST_STOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP && !cnt_wr) |=> (cnt_q == '0 && state_q == ST_STOP));  // R7
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_q && !(sts_clr_wr && sts_clr_wdata)) |=> sts_q);  // R8
    AST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_clr_wr && sts_clr_wdata && !expire) |=> !sts_q);  // R8
    AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ctl_q.ie);  // R9
endmodule

bind dec_timer_top dec_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
    .sts_clr_wr(sts_clr_wr), .sts_clr_wdata(sts_clr_wdata),
    .cnt_q(cnt_q), .rld_q(rld_q), .ctl_q(ctl_q), .state_q(state_q),
    .expire(expire), .sts_q(sts_q), .irq(irq)
);

// File: tb/sim_dec_timer_top.sv
module sim_dec_timer_top;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_en = 1'b0;
    logic         cnt_wr = 1'b0;
    logic [W-1:0] cnt_wdata = '0;
    logic         rld_wr = 1'b0;
    logic [W-1:0] rld_wdata = '0;
    logic         ctl_wr = 1'b0;
    logic [1:0]   ctl_wdata = '0;
    logic         sts_clr_wr = 1'b0;
    logic         sts_clr_wdata = 1'b0;
    logic [W-1:0] cnt_rdata;
    logic [W-1:0] rld_rdata;
    logic [1:0]   ctl_rdata;
    logic         sts_rdata;
    logic         dec_irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    dec_timer_top #(.CNT_W(W)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata),
        .rld_wr(rld_wr), .rld_wdata(rld_wdata),
        .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .sts_clr_wr(sts_clr_wr), .sts_clr_wdata(sts_clr_wdata),
        .cnt_rdata(cnt_rdata), .rld_rdata(rld_rdata), .ctl_rdata(ctl_rdata),
        .sts_rdata(sts_rdata), .dec_irq(dec_irq)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input string what,
                         input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // behavioural reference model
    longint m_cnt = 0, m_rld = 0;
    bit m_are = 0, m_ie = 0, m_sts = 0, m_armed = 0, m_ex;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_rld = 0; m_are = 0; m_ie = 0; m_sts = 0; m_armed = 0;
        end else begin
            m_ex = 0;
            if (cnt_wr) begin
                m_cnt = cnt_wdata;
                m_armed = 1;
            end else if (tick_en && m_armed) begin
                if (m_cnt <= 1) begin
                    m_ex = 1;
                    if (m_are && m_rld != 0) m_cnt = m_rld;
                    else begin m_cnt = 0; m_armed = 0; end
                end else m_cnt = m_cnt - 1;
            end
            if (sts_clr_wr && sts_clr_wdata) m_sts = 0;
            if (m_ex) m_sts = 1;
            if (rld_wr) m_rld = rld_wdata;
            if (ctl_wr) begin m_are = ctl_wdata[0]; m_ie = ctl_wdata[1]; end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R3", "model cnt", cnt_rdata, m_cnt);
            check("R8", "model sts", sts_rdata, m_sts);
            check("R5", "model irq", dec_irq, m_sts & m_ie);
            check("R10", "model rld", rld_rdata, m_rld);
            check("R9", "model ctl", ctl_rdata, {m_ie, m_are});
        end
    end

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 10);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        cyc(); cyc(); cyc();
        rst_n = 1'b1;
        // R1: reset state
        check("R1", "cnt", cnt_rdata, 0);
        check("R1", "rld", rld_rdata, 0);
        check("R1", "ctl", ctl_rdata, 0);
        check("R1", "sts", sts_rdata, 0);
        check("R1", "irq", dec_irq, 0);
        tick_en = 1; cyc(); cyc(); cyc();
        check("R1", "sts after idle ticks", sts_rdata, 0);
        check("R1", "cnt after idle ticks", cnt_rdata, 0);

        // R2: load with a concurrent tick
        cnt_wr = 1; cnt_wdata = 5; cyc(); cnt_wr = 0;
        check("R2", "loaded cnt", cnt_rdata, 5);
        cyc(); cyc();
        check("R3", "after two ticks", cnt_rdata, 3);
        tick_en = 0; cyc(); cyc();
        check("R3", "hold without tick", cnt_rdata, 3);
        tick_en = 1; cyc(); cyc();
        check("R3", "count one", cnt_rdata, 1);
        check("R4", "no expiry yet", sts_rdata, 0);
        cyc();
        check("R4", "expiry at one", sts_rdata, 1);
        check("R5", "irq gated off", dec_irq, 0);
        check("R7", "stop at zero", cnt_rdata, 0);
        cyc(); cyc(); cyc();
        check("R7", "stays zero", cnt_rdata, 0);
        tick_en = 0;

        // R5 / R8: enable interrupt and clear
        ctl_wr = 1; ctl_wdata = 2'b10; cyc(); ctl_wr = 0;
        check("R5", "irq on", dec_irq, 1);
        sts_clr_wr = 1; sts_clr_wdata = 0; cyc();
        check("R8", "clear with zero ignored", sts_rdata, 1);
        sts_clr_wdata = 1; cyc(); sts_clr_wr = 0;
        check("R8", "cleared", sts_rdata, 0);
        check("R8", "irq dropped", dec_irq, 0);

        // R6: auto-reload
        rld_wr = 1; rld_wdata = 3; ctl_wr = 1; ctl_wdata = 2'b11; cyc();
        rld_wr = 0; ctl_wr = 0;
        cnt_wr = 1; cnt_wdata = 2; cyc(); cnt_wr = 0;
        tick_en = 1; cyc(); cyc();
        check("R6", "reloaded", cnt_rdata, 3);
        check("R6", "status set", sts_rdata, 1);
        tick_en = 0; sts_clr_wr = 1; sts_clr_wdata = 1; cyc(); sts_clr_wr = 0;
        tick_en = 1; cyc(); cyc(); cyc();
        check("R6", "second period", cnt_rdata, 3);
        check("R6", "second expiry", sts_rdata, 1);
        // R8: clear coincides with expiry
        cyc(); cyc();
        sts_clr_wr = 1; sts_clr_wdata = 1; cyc(); sts_clr_wr = 0;
        check("R8", "set wins over clear", sts_rdata, 1);
        // R10: reload write coincides with expiry
        cyc(); cyc();
        rld_wr = 1; rld_wdata = 7; cyc(); rld_wr = 0;
        check("R10", "old reload used", cnt_rdata, 3);
        check("R10", "new reload held", rld_rdata, 7);
        cyc(); cyc(); cyc();
        check("R10", "new reload next", cnt_rdata, 7);

        // R7: zero reload value
        tick_en = 0;
        rld_wr = 1; rld_wdata = 0; sts_clr_wr = 1; sts_clr_wdata = 1; cyc();
        rld_wr = 0; sts_clr_wr = 0;
        cnt_wr = 1; cnt_wdata = 1; cyc(); cnt_wr = 0;
        tick_en = 1; cyc();
        check("R7", "expiry with zero reload", sts_rdata, 1);
        check("R7", "no reload of zero", cnt_rdata, 0);
        sts_clr_wr = 1; cyc(); sts_clr_wr = 0;
        cyc(); cyc(); cyc(); cyc();
        check("R7", "no refire", sts_rdata, 0);

        // R4: load zero then tick
        tick_en = 0; cnt_wr = 1; cnt_wdata = 0; cyc(); cnt_wr = 0;
        check("R4", "zero loaded no expiry", sts_rdata, 0);
        tick_en = 1; cyc();
        check("R4", "expiry after zero load", sts_rdata, 1);
        check("R4", "counter zero", cnt_rdata, 0);

        // R9: disable interrupt
        tick_en = 0; ctl_wr = 1; ctl_wdata = 2'b01; cyc(); ctl_wr = 0;
        check("R9", "irq off", dec_irq, 0);
        check("R9", "status kept", sts_rdata, 1);
        check("R9", "ctl readback", ctl_rdata, 1);

        // R2: load overrides expiry
        sts_clr_wr = 1; sts_clr_wdata = 1; cyc(); sts_clr_wr = 0;
        cnt_wr = 1; cnt_wdata = 1; cyc();
        tick_en = 1; cnt_wdata = 9; cyc(); cnt_wr = 0; tick_en = 0;
        check("R2", "load beats expiry cnt", cnt_rdata, 9);
        check("R2", "load beats expiry sts", sts_rdata, 0);
        cyc();
        finish_run();
    end
endmodule